// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches the 32 input pins of one general-purpose I/O port and turns selected pin activity into a single port interrupt line. Each pin carries a 2-bit trigger code that picks rising edge, falling edge, high level or low level. A pin can raise an interrupt only when software has claimed it for GPIO use and configured it as an input.

Detected events are latched into a pending-status word. Software clears pending bits by writing ones to that word. A mask word gates the pending bits, and the OR of every enabled, pending bit drives the port interrupt output. A chip with several ports uses one instance per port, and each instance drives its own interrupt line.

Software reaches the block through a plain synchronous register bus made of a word address, a write strobe, write data and registered read data. Pin inputs are asynchronous and are synchronized inside the block.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register (word addresses 0x0 to 0x5) reads zero and `irq_o` is low, so all pins start unused, input, rising-edge coded and masked.
- R2: Code 2'b00 sets a pin's status bit once per low-to-high transition. A pin held high does not set the bit again after it is cleared, and a falling transition has no effect.
- R3: Code 2'b01 sets a pin's status bit once per high-to-low transition. A rising transition has no effect.
- R4: Code 2'b10 sets the status bit on every cycle the pin is high, so a clear made while the pin is still high does not remove the bit.
- R5: Code 2'b11 sets the status bit on every cycle the pin is low.
- R6: The code for pins 0 to 15 sits in register 0x2 and the code for pins 16 to 31 sits in register 0x3, each at bits [2*(pin mod 16)+1 : 2*(pin mod 16)].
- R7: A pin takes part in detection only when its bit in the use register (0x0) is 1 and its bit in the direction register (0x1) is 0. Otherwise it never sets status.
- R8: Writing a 1 to a bit of the status register (0x5) clears that bit. Writing a 0 leaves the bit unchanged.
- R9: When a detection event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: `irq_o` equals the OR over all pins of status AND mask (register 0x4, 1 = enabled), registered one cycle. Status latches whether or not the pin is masked, so unmasking a pending bit raises `irq_o` on the next clock.
- R11: `rdata_o` returns the register selected by `addr_i` one clock later and shows the value from before any write in that same cycle. Addresses 0x6 to 0xF read zero and writes to them change nothing.
- R12: Each pin passes through a two-flop synchronizer. A pin change present before clock edge k sets its status bit at edge k+2 when it matches the configured trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | 32 | Asynchronous pin levels |
| irq_o | output | 1 | Port interrupt line |

## Verification
Directed stimulus moves individual pins through edges and held levels under each of the four trigger codes. Matching and opposite transitions separate the edge codes. Clears issued while a level is still active separate level triggering from edge triggering and show that set wins over clear. Pins left out of the use register, or configured as outputs, are held at levels that would otherwise trigger, which isolates the participation gate. A behavioural model runs alongside on every cycle and checks the exact latency of the synchronizer, status, read and interrupt stages.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_HIGH = 2'b10,
    TRIG_LOW  = 2'b11
  } trig_e;

  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_USE  = 4'h0;
  localparam logic [ADDR_W-1:0] A_DIR  = 4'h1;
  localparam logic [ADDR_W-1:0] A_TRLO = 4'h2;
  localparam logic [ADDR_W-1:0] A_TRHI = 4'h3;
  localparam logic [ADDR_W-1:0] A_MASK = 4'h4;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h5;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPIN-1:0]   lvl_i,
  input  logic [NPIN-1:0]   en_i,
  input  logic [2*NPIN-1:0] trig_i,
  output logic [NPIN-1:0]   evt_o
);
  logic [NPIN-1:0] prev_q;

  // previous sample tracks every pin so enabling never fakes an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    trig_e code;
    logic  hit;
    assign code = trig_e'(trig_i[2*p +: 2]);
    always_comb begin
      unique case (code)
        TRIG_RISE: hit =  lvl_i[p] & ~prev_q[p];
        TRIG_FALL: hit = ~lvl_i[p] &  prev_q[p];
        TRIG_HIGH: hit =  lvl_i[p];
        TRIG_LOW:  hit = ~lvl_i[p];
        default:   hit = 1'b0;
      endcase
    end
    assign evt_o[p] = hit & en_i[p];
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NPIN-1:0]   wdata_i,
  input  logic [NPIN-1:0]   evt_i,
  output logic [NPIN-1:0]   use_o,
  output logic [NPIN-1:0]   dir_o,
  output logic [2*NPIN-1:0] trig_o,
  output logic [NPIN-1:0]   mask_o,
  output logic [NPIN-1:0]   stat_o,
  output logic [NPIN-1:0]   rdata_o
);
  logic [NPIN-1:0] use_q, dir_q, trlo_q, trhi_q, mask_q, stat_q, rd_q;
  logic [NPIN-1:0] clr;
  logic [NPIN-1:0] rd_d;

  assign clr = (we_i && addr_i == A_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      use_q  <= '0;
      dir_q  <= '0;
      trlo_q <= '0;
      trhi_q <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_USE:   use_q  <= wdata_i;
        A_DIR:   dir_q  <= wdata_i;
        A_TRLO:  trlo_q <= wdata_i;
        A_TRHI:  trhi_q <= wdata_i;
        A_MASK:  mask_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // set beats clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | evt_i;
  end

  always_comb begin
    unique case (addr_i)
      A_USE:   rd_d = use_q;
      A_DIR:   rd_d = dir_q;
      A_TRLO:  rd_d = trlo_q;
      A_TRHI:  rd_d = trhi_q;
      A_MASK:  rd_d = mask_q;
      A_STAT:  rd_d = stat_q;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign use_o   = use_q;
  assign dir_o   = dir_q;
  assign trig_o  = {trhi_q, trlo_q};
  assign mask_o  = mask_q;
  assign stat_o  = stat_q;
  assign rdata_o = rd_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  output logic              irq_o
);
  logic [NPIN-1:0]   lvl, use_r, dir_r, mask_r, stat_r, evt, pin_en;
  logic [2*NPIN-1:0] trig_r;
  logic              irq_q;

  gpio_irq_sync #(.W(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  assign pin_en = use_r & ~dir_r;

  gpio_irq_detect #(.NPIN(NPIN)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .en_i  (pin_en),
    .trig_i(trig_r),
    .evt_o (evt)
  );

  gpio_irq_regs #(.NPIN(NPIN)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .we_i   (we_i),
    .wdata_i(wdata_i),
    .evt_i  (evt),
    .use_o  (use_r),
    .dir_o  (dir_r),
    .trig_o (trig_r),
    .mask_o (mask_r),
    .stat_o (stat_r),
    .rdata_o(rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_r & mask_r);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [NPIN-1:0]   wdata_i,
  input logic [NPIN-1:0]   rdata_o,
  input logic              irq_o,
  input logic [NPIN-1:0]   stat,
  input logic [NPIN-1:0]   mask,
  input logic [NPIN-1:0]   evt,
  input logic [NPIN-1:0]   en
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) $rose(rst_ni) |-> !irq_o && stat == '0); // R1

  AST_EVT_ONLY_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt & ~en) == '0); // R7

  AST_STAT_RISE_NEEDS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat & ~$past(stat) & ~$past(evt)) == '0); // R2

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(evt) & ~stat) == '0); // R9

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_STAT && wdata_i == '0) |=> ((stat & $past(stat)) == $past(stat))); // R8

  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |=> !irq_o); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > A_STAT) |=> (rdata_o == '0)); // R11
endmodule

bind gpio_irq_port gpio_irq_chk #(.NPIN(NPIN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .stat   (stat_r),
  .mask   (mask_r),
  .evt    (evt),
  .en     (pin_en)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] pin = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_use, m_dir, m_lo, m_hi, m_mask, m_stat, m_s1, m_s2, m_prev, m_rd;
  logic        m_irq;

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] ev, clr, rd;
    if (!rst_n) begin
      m_use = 0; m_dir = 0; m_lo = 0; m_hi = 0; m_mask = 0; m_stat = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_rd = 0; m_irq = 0;
    end else begin
      ev = 0;
      for (int p = 0; p < 32; p++) begin
        int code;
        code = (p < 16) ? int'((m_lo >> (2*p)) & 3) : int'((m_hi >> (2*(p-16))) & 3);
        if (m_use[p] && !m_dir[p]) begin
          if (code == 0) ev[p] = m_s2[p] && !m_prev[p];
          else if (code == 1) ev[p] = !m_s2[p] && m_prev[p];
          else if (code == 2) ev[p] = m_s2[p];
          else ev[p] = !m_s2[p];
        end
      end
      case (addr)
        4'h0: rd = m_use;   4'h1: rd = m_dir;
        4'h2: rd = m_lo;    4'h3: rd = m_hi;
        4'h4: rd = m_mask;  4'h5: rd = m_stat;
        default: rd = 0;
      endcase
      m_irq = |(m_stat & m_mask);
      m_rd = rd;
      clr = (we && addr == 4'h5) ? wdata : 0;
      if (we) begin
        case (addr)
          4'h0: m_use = wdata;  4'h1: m_dir = wdata;
          4'h2: m_lo = wdata;   4'h3: m_hi = wdata;
          4'h4: m_mask = wdata;
          default: ;
        endcase
      end
      m_stat = (m_stat & ~clr) | ev;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      check("R11 rdata vs model", rdata, m_rd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(4'(a), v);
      check("R1 reset read", v, 32'h0);
    end
    check("R1 irq after reset", {31'd0, irq}, 32'h0);

    // R6 codes: p1 fall, p2 high, p3 low, p4 low, p5 low, p17 high
    wr(4'h2, 32'h0000_0FE4);
    wr(4'h3, 32'h0000_0008);
    wr(4'h1, 32'h0000_0020);        // pin5 output
    wr(4'h0, 32'h0003_002F);        // pin4 not used
    rd(4'h2, v); check("R6 low-half code word", v, 32'h0000_0FE4);
    rd(4'h3, v); check("R6 high-half code word", v, 32'h0000_0008);

    // R12 latency on pin0 rising
    addr = 4'h5; pin = 32'h1;
    idle(3);
    check("R12 not yet visible", {31'd0, rdata[0]}, 32'h0);
    idle(1);
    check("R12 visible at k+2", {31'd0, rdata[0]}, 32'h1);

    idle(3);
    rd(4'h5, v); check("R5 low level and R7 gating", v, 32'h0000_0009);
    wr(4'h5, 32'hFFFF_FFFF);
    idle(2);
    rd(4'h5, v); check("R2 held high no re-set, R5 level re-sets", v, 32'h0000_0008);

    pin = 32'h0002_000D;
    idle(5);
    wr(4'h5, 32'hFFFF_FFFF);
    idle(1);
    rd(4'h5, v); check("R4 high level persists, R6 upper pin", v, 32'h0002_0004);

    pin = 32'h0000_000A;
    idle(5);
    wr(4'h5, 32'hFFFF_FFFF);
    idle(2);
    rd(4'h5, v); check("R3 rise ignored, R2 fall ignored", v, 32'h0);

    pin = 32'h0000_0008;
    idle(5);
    rd(4'h5, v); check("R3 falling edge", v, 32'h0000_0002);
    check("R10 masked pending keeps irq low", {31'd0, irq}, 32'h0);

    wr(4'h4, 32'h0000_0002);
    @(negedge clk);
    check("R10 unmask raises irq", {31'd0, irq}, 32'h1);

    wr(4'h5, 32'h0);
    rd(4'h5, v); check("R8 zero write keeps", v, 32'h0000_0002);
    wr(4'h5, 32'h0000_0002);
    rd(4'h5, v); check("R8 one write clears", v, 32'h0);
    check("R10 irq drops after clear", {31'd0, irq}, 32'h0);

    pin = 32'h0000_000C;
    idle(5);
    wr(4'h5, 32'h0000_0004);
    rd(4'h5, v); check("R9 set beats clear", v, 32'h0000_0004);

    wr(4'hA, 32'hFFFF_FFFF);
    rd(4'hA, v); check("R11 unmapped reads zero", v, 32'h0);
    rd(4'h4, v); check("R11 unmapped write ignored", v, 32'h0000_0002);
    rd(4'h0, v); check("R11 use word intact", v, 32'h0003_002F);

    idle(2);
    finish_run();
  end
endmodule